// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad split into sixteen 32-bit banks that serves a group of sixteen parallel request lanes. Each lane carries an active flag, a word address, a write enable and write data. A group is taken through a valid/ready handshake. The block then works out which lanes land in the same bank. It runs as many internal passes as the most crowded bank needs, and raises a one-cycle done pulse with every lane's read word presented at once.

Word addresses are interleaved across the banks. Any access pattern whose lanes fall in distinct banks completes in one pass. A group in which every active lane reads the very same word is also finished in one pass, with that word copied to every lane. Any other pileup on a bank is split into sequential passes. The latency of a group therefore depends on its data: it equals its worst bank load. Compute engines use the block as shared working storage. They can shape their address strides to stay on the single-pass path.

Top module: `banked_scratchpad`

## Requirements
- R1: A word address selects bank = address modulo 16 (its four low bits) and row = address divided by 16; a word written at any address is returned by a later read of that address.
- R2: A group whose active lanes all map to distinct banks finishes in one pass: done rises on the second clock edge after the accepting edge is counted as edge 0, i.e. at edge 1, and rsp_passes reads 1.
- R3: A group in which every active lane reads (write enable low) one identical address finishes in one pass and every active lane receives that word.
- R4: Otherwise the number of passes, reported on rsp_passes and seen as done at edge P after acceptance, equals the largest count of active lanes mapped to one bank; lanes naming the same word count as colliding.
- R5: For a linear pattern where lane i reads address base + s*i, odd strides s=1 and s=3 take 1 pass, s=2 takes 2 passes and s=8 takes 8 passes.
- R6: In each pass every bank serves its lowest-numbered pending lane, so lanes of one bank take effect in ascending lane order: a read by a lower lane sees the old word, a read by a higher lane sees an earlier lane's write, and of two writes to one word the higher lane's value remains.
- R7: req_ready is low from the accepting edge until the cycle after the done pulse; a new group is accepted only when req_ready is high.
- R8: rsp_done is high for exactly one cycle per group; rsp_rdata and rsp_passes are valid in that cycle and hold their values until the next group is accepted.
- R9: Inactive lanes enter no bank arbitration and return zero; a group with no active lane finishes after one pass with rsp_passes equal to 1.
- R10: A lane that writes returns zero as its read data.
- R11: While reset is applied and in the cycles after its release, rsp_done is low and rsp_rdata is zero; req_ready rises within three cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request group is presented |
| req_ready | output | 1 | The block can take a group this cycle |
| req_act | input | 16 | Per-lane active flag |
| req_addr | input | 160 | Per-lane word address, lane i in bits [10*i+9 : 10*i] |
| req_we | input | 16 | Per-lane write enable |
| req_wdata | input | 512 | Per-lane write word, lane i in bits [32*i+31 : 32*i] |
| rsp_done | output | 1 | One-cycle pulse: the group is finished |
| rsp_rdata | output | 512 | Per-lane read word, lane i in bits [32*i+31 : 32*i] |
| rsp_passes | output | 5 | Passes the finished group needed |

## Verification
A wrong pending mask or a faulty bank grant shows up as a wrong pass count. The done pulse then arrives one or more cycles too early or too late, so the per-cycle comparison catches it at the first mismatching edge. A corrupted serving order or a bad bank or row split leaves the right timing but wrong words. These show up in rsp_rdata at the done cycle, or in a later read of the words written. A broadcast flag set in error also shows up there, as a collapsed pass count or as lanes receiving a word they did not ask for.

// File: rtl/spb_pkg.sv
package spb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } spb_state_e;

endpackage

// File: rtl/spb_bank.sv
module spb_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] mem_q [ROWS];

  // write lands on the clock edge that closes the pass
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[row] <= wdata;
    end
  end

  // register-file style read, visible within the pass
  assign rdata = mem_q[row];

endmodule

// File: rtl/spb_bank_arbiter.sv
module spb_bank_arbiter #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic [LANES-1:0]                      pend,
  input  logic [LANES-1:0][ADDR_W-1:0]          addr,
  input  logic [LANES-1:0]                      we,
  input  logic [LANES-1:0][DATA_W-1:0]          wdata,
  output logic [LANES-1:0]                      grant,
  output logic [BANKS-1:0]                      bank_wr,
  output logic [BANKS-1:0][ADDR_W-$clog2(BANKS)-1:0] bank_row,
  output logic [BANKS-1:0][DATA_W-1:0]          bank_wdata
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;

  logic [BANKS-1:0]  taken;
  logic [BANK_W-1:0] sel;

  // lanes scanned upward: the first pending lane claims its bank
  always_comb begin
    taken      = '0;
    grant      = '0;
    bank_wr    = '0;
    bank_row   = '0;
    bank_wdata = '0;
    sel        = '0;
    for (int l = 0; l < LANES; l++) begin
      sel = addr[l][BANK_W-1:0];
      if (pend[l] && !taken[sel]) begin
        taken[sel]      = 1'b1;
        grant[l]        = 1'b1;
        bank_wr[sel]    = we[l];
        bank_row[sel]   = addr[l][ADDR_W-1:BANK_W];
        bank_wdata[sel] = wdata[l];
      end
    end
  end

endmodule

// File: rtl/spb_bcast_detect.sv
module spb_bcast_detect #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 10
) (
  input  logic [LANES-1:0]             act,
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0]             we,
  output logic                         bcast
);

  logic              seen;
  logic [ADDR_W-1:0] first_addr;

  // every active lane reads the address of the first active lane
  always_comb begin
    bcast      = 1'b1;
    seen       = 1'b0;
    first_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (act[l]) begin
        if (we[l]) begin
          bcast = 1'b0;
        end
        if (!seen) begin
          seen       = 1'b1;
          first_addr = addr[l];
        end else if (addr[l] != first_addr) begin
          bcast = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [LANES-1:0]           req_act,
  input  logic [LANES*ADDR_W-1:0]    req_addr,
  input  logic [LANES-1:0]           req_we,
  input  logic [LANES*DATA_W-1:0]    req_wdata,
  output logic                       rsp_done,
  output logic [LANES*DATA_W-1:0]    rsp_rdata,
  output logic [$clog2(LANES+1)-1:0] rsp_passes
);

  import spb_pkg::*;

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int CNT_W  = $clog2(LANES + 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  // group state
  spb_state_e                       state_q, state_d;
  logic [LANES-1:0]                 act_q, act_d;
  logic [LANES-1:0]                 we_q, we_d;
  logic [LANES-1:0][ADDR_W-1:0]     addr_q, addr_d;
  logic [LANES-1:0][DATA_W-1:0]     wdata_q, wdata_d;
  logic [LANES-1:0]                 pend_q, pend_d;
  logic                             bcast_q, bcast_d;
  logic [LANES-1:0][DATA_W-1:0]     res_q, res_d;
  logic [CNT_W-1:0]                 passes_q, passes_d;
  logic                             state_en, load_en, pass_en;

  // unpacked views of the request buses
  logic [LANES-1:0][ADDR_W-1:0]     in_addr;
  logic [LANES-1:0][DATA_W-1:0]     in_wdata;

  // datapath nets
  logic                             accept;
  logic                             busy;
  logic                             bcast_in;
  logic [LANES-1:0]                 grant;
  logic [LANES-1:0]                 cap;
  logic [BANKS-1:0]                 bank_wr;
  logic [BANKS-1:0][ROW_W-1:0]      bank_row;
  logic [BANKS-1:0][DATA_W-1:0]     bank_wdata;
  logic [BANKS-1:0][DATA_W-1:0]     bank_rdata;
  logic [LANES-1:0][DATA_W-1:0]     lane_rd;

  genvar gl, gb;

  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      assign in_addr[gl]  = req_addr[gl*ADDR_W +: ADDR_W];
      assign in_wdata[gl] = req_wdata[gl*DATA_W +: DATA_W];
      assign lane_rd[gl]  = bank_rdata[addr_q[gl][BANK_W-1:0]];
      assign cap[gl]      = busy && act_q[gl] && !we_q[gl] && (grant[gl] || bcast_q);
      assign rsp_rdata[gl*DATA_W +: DATA_W] = res_q[gl];
    end
  endgenerate

  assign busy      = (state_q == ST_BUSY);
  assign req_ready = (state_q == ST_IDLE) && rst_int_n;
  assign accept    = req_valid && req_ready;
  assign rsp_done  = (state_q == ST_DONE);
  assign rsp_passes = passes_q;

  spb_bcast_detect #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
  ) i_bcast (
    .act   (req_act),
    .addr  (in_addr),
    .we    (req_we),
    .bcast (bcast_in)
  );

  spb_bank_arbiter #(
    .LANES  (LANES),
    .BANKS  (BANKS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_arb (
    .pend       (pend_q),
    .addr       (addr_q),
    .we         (we_q),
    .wdata      (wdata_q),
    .grant      (grant),
    .bank_wr    (bank_wr),
    .bank_row   (bank_row),
    .bank_wdata (bank_wdata)
  );

  generate
    for (gb = 0; gb < BANKS; gb++) begin : g_bank
      spb_bank #(
        .DATA_W (DATA_W),
        .ROW_W  (ROW_W)
      ) i_bank (
        .clk   (clk),
        .wr_en (busy && bank_wr[gb]),
        .row   (bank_row[gb]),
        .wdata (bank_wdata[gb]),
        .rdata (bank_rdata[gb])
      );
    end
  endgenerate

  // next-state process
  always_comb begin
    state_d  = state_q;
    act_d    = act_q;
    we_d     = we_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    pend_d   = pend_q;
    bcast_d  = bcast_q;
    res_d    = res_q;
    passes_d = passes_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          act_d    = req_act;
          we_d     = req_we;
          addr_d   = in_addr;
          wdata_d  = in_wdata;
          pend_d   = req_act;
          bcast_d  = bcast_in;
          res_d    = '0;
          passes_d = '0;
          state_d  = ST_BUSY;
        end
      end
      ST_BUSY: begin
        passes_d = passes_q + CNT_W'(1);
        for (int l = 0; l < LANES; l++) begin
          if (cap[l]) begin
            res_d[l] = lane_rd[l];
          end
        end
        pend_d = bcast_q ? '0 : (pend_q & ~grant);
        if (pend_d == '0) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // clock enables
  assign state_en = (state_q != ST_IDLE) || accept;
  assign load_en  = accept;
  assign pass_en  = busy || accept;

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      act_q    <= '0;
      we_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      pend_q   <= '0;
      bcast_q  <= 1'b0;
      res_q    <= '0;
      passes_q <= '0;
    end else begin
      if (state_en) begin
        state_q <= state_d;
      end
      if (load_en) begin
        act_q   <= act_d;
        we_q    <= we_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        bcast_q <= bcast_d;
      end
      if (pass_en) begin
        pend_q   <= pend_d;
        res_q    <= res_d;
        passes_q <= passes_d;
      end
    end
  end

endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
  parameter int LANES  = 16,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       rsp_done,
  input logic [$clog2(LANES+1)-1:0] rsp_passes,
  input logic [LANES*DATA_W-1:0]    rsp_rdata,
  input logic [LANES-1:0]           act_q,
  input logic [LANES-1:0]           pend_q,
  input logic [LANES-1:0]           grant,
  input logic                       busy
);

  // R7: taking a group drops ready on the next cycle
  p_accept_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: no acceptance while the done pulse is out
  p_done_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);

  // R7: ready returns right after done
  p_ready_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R8: results hold in the cycle after done
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> $stable(rsp_rdata));

  // R4: pass count of a finished group lies between 1 and the lane count
  p_passes_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_passes >= 1 && int'(rsp_passes) <= LANES));

  // R4: pending lanes only ever drain while serializing
  p_pending_drains_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pend_q & ~$past(pend_q)) == '0));

  // R9: grants go only to lanes of the accepted active set
  p_grant_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((grant & ~act_q) == '0));

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane_chk
      // R9: an inactive lane returns zero
      p_inactive_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !act_q[gl]) |-> (rsp_rdata[gl*DATA_W +: DATA_W] == '0));
    end
  endgenerate

endmodule

bind banked_scratchpad spb_checker #(
  .LANES  (LANES),
  .DATA_W (DATA_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .rsp_passes (rsp_passes),
  .rsp_rdata  (rsp_rdata),
  .act_q      (act_q),
  .pend_q     (pend_q),
  .grant      (grant),
  .busy       (busy)
);

// File: tb/test_banked_scratchpad.sv
`timescale 1ns/1ps
module test_banked_scratchpad;

  localparam int LANES  = 16;
  localparam int BANKS  = 16;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(LANES + 1);

  logic                    clk;
  logic                    rst_n;
  logic                    req_valid;
  logic                    req_ready;
  logic [LANES-1:0]        req_act;
  logic [LANES*ADDR_W-1:0] req_addr;
  logic [LANES-1:0]        req_we;
  logic [LANES*DATA_W-1:0] req_wdata;
  logic                    rsp_done;
  logic [LANES*DATA_W-1:0] rsp_rdata;
  logic [CNT_W-1:0]        rsp_passes;

  banked_scratchpad #(
    .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_banked_scratchpad (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_act(req_act), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_passes(rsp_passes)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  bit          g_act  [LANES];
  int          g_addr [LANES];
  bit          g_we   [LANES];
  logic [31:0] g_wd   [LANES];
  logic [31:0] mdl_mem [WORDS];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL R7 watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [31:0] pattern(input int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic clear_lanes();
    for (int l = 0; l < LANES; l++) begin
      g_act[l] = 1'b0; g_addr[l] = 0; g_we[l] = 1'b0; g_wd[l] = '0;
    end
  endtask

  task automatic stride_read(input int base, input int s);
    for (int l = 0; l < LANES; l++) begin
      g_act[l] = 1'b1; g_addr[l] = (base + s * l) % WORDS; g_we[l] = 1'b0; g_wd[l] = '0;
    end
  endtask

  // behavioural model: lanes in ascending order, passes from bank loads
  task automatic run_group(input string req, input int want_p);
    logic [31:0] exp_res [LANES];
    int          load [BANKS];
    int          p;
    bit          bc;
    bit          seen;
    int          first;
    logic [LANES*DATA_W-1:0] held;

    bc = 1'b1; seen = 1'b0; first = 0;
    for (int b = 0; b < BANKS; b++) load[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      if (g_act[l]) begin
        if (g_we[l]) bc = 1'b0;
        if (!seen) begin seen = 1'b1; first = g_addr[l]; end
        else if (g_addr[l] != first) bc = 1'b0;
        load[g_addr[l] % BANKS]++;
      end
    end
    p = 1;
    if (!bc) begin
      for (int b = 0; b < BANKS; b++) if (load[b] > p) p = load[b];
    end
    for (int l = 0; l < LANES; l++) begin
      exp_res[l] = '0;
      if (g_act[l]) begin
        if (g_we[l]) mdl_mem[g_addr[l]] = g_wd[l];
        else         exp_res[l] = mdl_mem[g_addr[l]];
      end
    end
    if (want_p > 0) chk(p == want_p, req, "model pass count", p, want_p);

    @(negedge clk);
    chk(req_ready === 1'b1, "R7", "ready before group", req_ready, 1);
    req_valid = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      req_act[l] = g_act[l];
      req_we[l]  = g_we[l];
      req_addr[l*ADDR_W +: ADDR_W]  = ADDR_W'(g_addr[l]);
      req_wdata[l*DATA_W +: DATA_W] = g_wd[l];
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_act   = '0;
    chk(req_ready === 1'b0, "R7", "ready after accept", req_ready, 0);
    chk(rsp_done === 1'b0, "R8", "done right after accept", rsp_done, 0);
    for (int k = 1; k <= p; k++) begin
      @(negedge clk);
      chk(rsp_done === (k == p), req, $sformatf("done at pass %0d of %0d", k, p), rsp_done, (k == p));
      chk(req_ready === 1'b0, "R7", "ready while serializing", req_ready, 0);
    end
    chk(int'(rsp_passes) == p, req, "pass count", rsp_passes, p);
    for (int l = 0; l < LANES; l++) begin
      chk(rsp_rdata[l*DATA_W +: DATA_W] === exp_res[l], req,
          $sformatf("lane %0d data", l), rsp_rdata[l*DATA_W +: DATA_W], exp_res[l]);
    end
    held = rsp_rdata;
    @(negedge clk);
    chk(rsp_done === 1'b0, "R8", "done lasts one cycle", rsp_done, 0);
    chk(req_ready === 1'b1, "R7", "ready after done", req_ready, 1);
    chk(rsp_rdata === held, "R8", "data held after done", 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_act = '0; req_addr = '0; req_we = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(rsp_done === 1'b0, "R11", "done in reset", rsp_done, 0);
    chk(rsp_rdata === '0, "R11", "rdata in reset", 0, 0);
    chk(req_ready === 1'b0, "R11", "ready in reset", req_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready after release", req_ready, 1);
    chk(rsp_done === 1'b0, "R11", "done after release", rsp_done, 0);

    // R1 R2 R10: fill every word, distinct banks per group
    for (int g = 0; g < WORDS / LANES; g++) begin
      for (int l = 0; l < LANES; l++) begin
        g_act[l] = 1'b1; g_we[l] = 1'b1; g_addr[l] = g * LANES + l; g_wd[l] = pattern(g * LANES + l);
      end
      run_group("R2", 1);
    end

    // R5: strides
    stride_read(0, 1);   run_group("R5", 1);
    stride_read(5, 3);   run_group("R5", 1);
    stride_read(2, 2);   run_group("R5", 2);
    stride_read(1, 8);   run_group("R5", 8);

    // R1: all lanes in bank 3, different rows
    stride_read(3, 16);  run_group("R1", 16);
    stride_read(1008, 1); run_group("R1", 1);

    // R3: broadcast read
    clear_lanes();
    for (int l = 0; l < LANES; l++) begin g_act[l] = 1'b1; g_addr[l] = 37; end
    run_group("R3", 1);

    // R4 R6: same word with one writer, not a broadcast
    for (int l = 0; l < LANES; l++) begin g_act[l] = 1'b1; g_addr[l] = 50; g_we[l] = 1'b0; end
    g_we[4] = 1'b1; g_wd[4] = 32'hCAFE_0004;
    run_group("R6", 16);

    // R4: sub-word packing, two and four lanes per word
    clear_lanes();
    for (int l = 0; l < LANES; l++) begin g_act[l] = 1'b1; g_addr[l] = 200 + l / 2; end
    run_group("R4", 2);
    for (int l = 0; l < LANES; l++) begin g_act[l] = 1'b1; g_addr[l] = 300 + l / 4; end
    run_group("R4", 4);

    // R6: two writers to one word, higher lane wins; reads around them
    clear_lanes();
    g_act[0] = 1'b1; g_we[0] = 1'b1; g_addr[0] = 100; g_wd[0] = 32'h1111_0000;
    g_act[2] = 1'b1; g_addr[2] = 100;
    g_act[5] = 1'b1; g_we[5] = 1'b1; g_addr[5] = 100; g_wd[5] = 32'h5555_0000;
    g_act[9] = 1'b1; g_addr[9] = 100;
    run_group("R6", 4);
    clear_lanes();
    g_act[7] = 1'b1; g_addr[7] = 100;
    run_group("R6", 1);

    // R9: sparse mask and empty group
    clear_lanes();
    g_act[3] = 1'b1; g_addr[3] = 19;
    g_act[9] = 1'b1; g_addr[9] = 35;
    run_group("R9", 2);
    clear_lanes();
    run_group("R9", 1);

    // R10: mixed writes and reads across banks
    clear_lanes();
    for (int l = 0; l < LANES; l++) begin
      g_act[l] = 1'b1; g_addr[l] = 512 + l; g_we[l] = l[0]; g_wd[l] = 32'hA000_0000 + l;
    end
    run_group("R10", 1);
    stride_read(512, 1); run_group("R10", 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule